// File: doc/BRIEF.md
# Register-File Burst Byte Mover

This block copies a run of bytes between a 32-entry, 32-bit register file and a byte-addressed data memory. A load reads memory into the registers and a store writes register bytes out to memory. Each command carries a memory address, a byte count, a starting register and a starting byte lane inside that register. The block moves one byte per clock. After lane 3 of a register it continues at lane 0 of the next register. The lowest memory address of the run always pairs with the starting lane, so the image in memory is little-endian.

Before any byte moves, the command is screened. A run that would step past the last byte of the register file is refused as an illegal operation. An optional low-address trap refuses accesses that start below address 4. An optional region guard refuses runs that touch or cross a configurable instruction-space base. A refused command changes no register and no memory byte. Every command ends with a one-cycle `done` pulse, which carries the error flags and the cycle charge of the instruction.

The register file sits inside the block. The surrounding core writes and reads whole words through a host port. Memory is reached through a byte port with one cycle of read latency.

Top module: `rf_burst_mover`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `err_illegal`, `err_fault`, `mem_re`, `mem_we` and `cost` are 0, and every register reads 0.
- R2: A store of N bytes drives `mem_we` in the N cycles that follow the accepting edge. The byte sent to address `cmd_addr`+i comes from lane (L+i) mod 4 of register R+(L+i) div 4, where R is the starting register and L the starting lane. Lane k is bits 8k+7:8k, and `mem_we` and `mem_re` are never high together.
- R3: A load of N bytes issues `mem_re` for addresses `cmd_addr`..`cmd_addr`+N-1, using the same register and lane order as R2. Each byte is merged into its own lane, and the other lanes of that register keep their values.
- R4: When `cmd_reg`*4 + `cmd_lane` + `cmd_count` is greater than 128, the command ends with `done` and `err_illegal`. It moves no byte and changes no register. A sum of exactly 128 is legal.
- R5: When `null_trap_en` is 1 and `cmd_addr` is below 4, the command ends with `done` and `err_fault` and moves no byte. With the trap disabled, address 0 is an ordinary address.
- R6: When `region_chk_en` is 1, a command faults in the same way as R5 if `cmd_addr` >= `space_base` or `cmd_addr` + `cmd_count` > `space_base`. A run that ends exactly at `space_base` is legal.
- R7: When a command meets both a fault condition and the R4 condition, only `err_fault` is raised.
- R8: A legal command with count 0 raises `done` in the first cycle after the accepting edge. It raises no error and drives no memory access.
- R9: `done` is a one-cycle pulse, and `busy` is high from the cycle after acceptance through the `done` cycle. `done` comes 1 cycle after acceptance for refused or zero-count commands, N+1 cycles after for a store and N+2 cycles after for a load.
- R10: `cost` is 3 during `done` for a command that was not refused (one base cycle plus two memory cycles). It is 0 during `done` of a refused command and 0 whenever `done` is low.
- R11: A `start` seen while `busy` is high is ignored, and so is a host register write (`rf_wr_en`) seen while `busy` is high.
- R12: Registers 30 and 31 are ordinary transfer targets. A load into register 30 lane 0 with count 8 fills both registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Command strobe, accepted only when idle |
| is_store | input | 1 | 1 = registers to memory, 0 = memory to registers |
| cmd_addr | input | 32 | First memory byte address |
| cmd_count | input | 7 | Number of bytes |
| cmd_reg | input | 5 | Starting register |
| cmd_lane | input | 2 | Starting byte lane |
| null_trap_en | input | 1 | Enable low-address trap |
| region_chk_en | input | 1 | Enable instruction-space guard |
| space_base | input | 32 | Instruction-space base address |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err_illegal | output | 1 | Register-file overrun, valid with done |
| err_fault | output | 1 | Access fault, valid with done |
| cost | output | 3 | Cycle charge, valid with done |
| mem_re | output | 1 | Memory byte read request |
| mem_we | output | 1 | Memory byte write strobe |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, one cycle after mem_re |
| rf_wr_en | input | 1 | Host word write enable |
| rf_wr_idx | input | 5 | Host write register |
| rf_wr_data | input | 32 | Host write word |
| rf_rd_idx | input | 5 | Host read register |
| rf_rd_data | output | 32 | Host read word |

## Verification
A wrong lane or register pointer shows up as a misplaced byte. For a store it is visible on `mem_wdata` in the same cycle, and for a load it is visible in the register file once `done` rises. A lane-wrap error appears at the first register boundary the run crosses. A stuck or mis-sequenced control state shows up as a `done` that arrives early or late, or as `mem_re`/`mem_we` activity on a refused or zero-length command. That is visible within one cycle of acceptance. A fault check that is wrong shows up in the error flags and the cost during the first `done`.

// File: rtl/rfx_pkg.sv
// Shared types for the register-file burst byte mover.
package rfx_pkg;

    // Control phases of one command.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // waiting for start
        ST_RUN   = 2'd1,   // one byte per cycle on the memory port
        ST_DRAIN = 2'd2,   // last load byte returning from memory
        ST_FIN   = 2'd3    // done pulse
    } eng_state_t;

endpackage

// File: rtl/rfx_cmd_check.sv
// Command screen: decides whether a command is refused before any byte moves.
// Assumes a purely combinational use at the accepting edge. A fault (low-address
// trap or instruction-space guard) masks the register-overrun result.
module rfx_cmd_check #(
    parameter int AW         = 32,
    parameter int CW         = 7,
    parameter int RW         = 5,
    parameter int NREG       = 32,
    parameter int NULL_LIMIT = 4
) (
    input  logic [AW-1:0] addr,
    input  logic [CW-1:0] count,
    input  logic [RW-1:0] reg_idx,
    input  logic [1:0]    lane,
    input  logic          null_en,
    input  logic          region_en,
    input  logic [AW-1:0] space_base,
    output logic          illegal,
    output logic          fault
);
    localparam int SW      = (((RW + 2) > CW) ? (RW + 2) : CW) + 1;
    localparam int RF_BYTE = NREG * 4;

    logic [SW-1:0] span;
    logic [AW:0]   run_end;
    logic          null_hit;
    logic          region_hit;
    logic          overrun;

    // Span of register bytes the run would reach.
    always_comb begin
        span    = SW'({reg_idx, 2'b00}) + SW'(lane) + SW'(count);
        overrun = (span > SW'(RF_BYTE));
    end

    // Address screens: low-address trap and instruction-space guard.
    always_comb begin
        run_end    = {1'b0, addr} + (AW + 1)'(count);
        null_hit   = null_en && (addr < AW'(NULL_LIMIT));
        region_hit = region_en && ((addr >= space_base) || (run_end > {1'b0, space_base}));
        fault      = null_hit || region_hit;
        illegal    = overrun && !fault;
    end

endmodule

// File: rtl/rfx_seq.sv
// Byte sequencer: holds the current memory address, register, lane and
// remaining count, and advances one byte per step. Lane 3 wraps to lane 0
// of the next register. Assumes load and step are never high together.
module rfx_seq #(
    parameter int AW = 32,
    parameter int CW = 7,
    parameter int RW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] ld_addr,
    input  logic [CW-1:0] ld_count,
    input  logic [RW-1:0] ld_reg,
    input  logic [1:0]    ld_lane,
    output logic [AW-1:0] cur_addr,
    output logic [RW-1:0] cur_reg,
    output logic [1:0]    cur_lane,
    output logic          last
);
    logic [CW-1:0] remain;

    // Pointer registers: capture on load, advance on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            cur_reg  <= '0;
            cur_lane <= '0;
            remain   <= '0;
        end else if (load) begin
            cur_addr <= ld_addr;
            cur_reg  <= ld_reg;
            cur_lane <= ld_lane;
            remain   <= ld_count;
        end else if (step) begin
            cur_addr <= cur_addr + 1'b1;
            cur_lane <= cur_lane + 1'b1;
            remain   <= remain - 1'b1;
            if (cur_lane == 2'd3) begin
                cur_reg <= cur_reg + 1'b1;
            end
        end
    end

    // Final byte flag for the controller.
    always_comb last = (remain == CW'(1));

    // R2: lane 3 steps on to lane 0 of the following register
    a_r2_lane_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && cur_lane == 2'd3) |=> (cur_lane == 2'd0 && cur_reg == RW'($past(cur_reg) + 1'b1)));

    // R2: a step inside a register keeps the register and moves one lane
    a_r2_lane_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && cur_lane != 2'd3) |=> (cur_reg == $past(cur_reg) && cur_lane == 2'($past(cur_lane) + 1'b1)));

    // R3: memory address climbs by one byte per step
    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (cur_addr == AW'($past(cur_addr) + 1'b1)));

endmodule

// File: rtl/rfx_regfile.sv
// Register file with a host word port and an engine byte port. The engine
// byte write changes one lane only. Assumes the controller gates host writes
// so that the two write ports never collide on the same cycle.
module rfx_regfile #(
    parameter int NREG = 32,
    parameter int RW   = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_idx,
    input  logic [31:0]   wr_data,
    input  logic [RW-1:0] rd_idx,
    output logic [31:0]   rd_data,
    input  logic [RW-1:0] br_idx,
    input  logic [1:0]    br_lane,
    output logic [7:0]    br_data,
    input  logic          bw_en,
    input  logic [RW-1:0] bw_idx,
    input  logic [1:0]    bw_lane,
    input  logic [7:0]    bw_data
);
    logic [31:0] regs [NREG];

    // Storage: byte merge from the engine, else a whole word from the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < NREG; g++) begin
                regs[g] <= '0;
            end
        end else if (bw_en) begin
            regs[bw_idx][{bw_lane, 3'b000} +: 8] <= bw_data;
        end else if (wr_en) begin
            regs[wr_idx] <= wr_data;
        end
    end

    // Read ports: whole word for the host, one byte for the engine.
    always_comb begin
        rd_data = regs[rd_idx];
        br_data = regs[br_idx][{br_lane, 3'b000} +: 8];
    end

    // R3: a byte merge into lane 0 leaves the upper three lanes alone
    a_r3_merge_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (bw_en && bw_lane == 2'd0) |=> (regs[$past(bw_idx)][31:8] == $past(regs[bw_idx][31:8])));

    // R3: the written lane takes the returned byte
    a_r3_merge_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (bw_en && bw_lane == 2'd3) |=> (regs[$past(bw_idx)][31:24] == $past(bw_data)));

endmodule

// File: rtl/rf_burst_mover.sv
// Register-file burst byte mover, top level. Accepts a command when idle,
// screens it, then moves one byte per cycle between the register file and a
// byte memory with one cycle of read latency. Ends every command with a
// one-cycle done pulse that carries the error flags and the cycle charge.
module rf_burst_mover #(
    parameter int NREG       = 32,
    parameter int AW         = 32,
    parameter int CW         = 7,
    parameter int NULL_LIMIT = 4,
    parameter int BASE_COST  = 1,
    parameter int MEM_EXTRA  = 2,
    parameter int COST_W     = 3,
    parameter int RW         = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_store,
    input  logic [AW-1:0]     cmd_addr,
    input  logic [CW-1:0]     cmd_count,
    input  logic [RW-1:0]     cmd_reg,
    input  logic [1:0]        cmd_lane,
    input  logic              null_trap_en,
    input  logic              region_chk_en,
    input  logic [AW-1:0]     space_base,
    output logic              busy,
    output logic              done,
    output logic              err_illegal,
    output logic              err_fault,
    output logic [COST_W-1:0] cost,
    output logic              mem_re,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              rf_wr_en,
    input  logic [RW-1:0]     rf_wr_idx,
    input  logic [31:0]       rf_wr_data,
    input  logic [RW-1:0]     rf_rd_idx,
    output logic [31:0]       rf_rd_data
);
    import rfx_pkg::*;

    localparam int FULL_COST = BASE_COST + MEM_EXTRA;

    eng_state_t    state;
    logic          st_q;
    logic          ill_q;
    logic          flt_q;
    logic          chk_ill;
    logic          chk_flt;
    logic          accept;
    logic          step;
    logic          last;
    logic [AW-1:0] cur_addr;
    logic [RW-1:0] cur_reg;
    logic [1:0]    cur_lane;
    logic          pend_v;
    logic [RW-1:0] pend_reg;
    logic [1:0]    pend_lane;
    logic [7:0]    store_byte;
    logic          host_we;

    rfx_cmd_check #(
        .AW(AW), .CW(CW), .RW(RW), .NREG(NREG), .NULL_LIMIT(NULL_LIMIT)
    ) u_check (
        .addr       (cmd_addr),
        .count      (cmd_count),
        .reg_idx    (cmd_reg),
        .lane       (cmd_lane),
        .null_en    (null_trap_en),
        .region_en  (region_chk_en),
        .space_base (space_base),
        .illegal    (chk_ill),
        .fault      (chk_flt)
    );

    rfx_seq #(
        .AW(AW), .CW(CW), .RW(RW)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .step     (step),
        .ld_addr  (cmd_addr),
        .ld_count (cmd_count),
        .ld_reg   (cmd_reg),
        .ld_lane  (cmd_lane),
        .cur_addr (cur_addr),
        .cur_reg  (cur_reg),
        .cur_lane (cur_lane),
        .last     (last)
    );

    rfx_regfile #(
        .NREG(NREG), .RW(RW)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (host_we),
        .wr_idx  (rf_wr_idx),
        .wr_data (rf_wr_data),
        .rd_idx  (rf_rd_idx),
        .rd_data (rf_rd_data),
        .br_idx  (cur_reg),
        .br_lane (cur_lane),
        .br_data (store_byte),
        .bw_en   (pend_v),
        .bw_idx  (pend_reg),
        .bw_lane (pend_lane),
        .bw_data (mem_rdata)
    );

    // Acceptance, stepping and host-write gating.
    always_comb begin
        accept  = start && (state == ST_IDLE);
        step    = (state == ST_RUN);
        host_we = rf_wr_en && (state == ST_IDLE);
    end

    // Controller: screen on accept, stream bytes, drain a load, pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            st_q  <= 1'b0;
            ill_q <= 1'b0;
            flt_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        st_q  <= is_store;
                        ill_q <= chk_ill;
                        flt_q <= chk_flt;
                        if (chk_ill || chk_flt || (cmd_count == '0)) begin
                            state <= ST_FIN;
                        end else begin
                            state <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    if (last) begin
                        state <= st_q ? ST_FIN : ST_DRAIN;
                    end
                end
                ST_DRAIN: state <= ST_FIN;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Load return tracker: remembers where the byte now in flight must land.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v    <= 1'b0;
            pend_reg  <= '0;
            pend_lane <= '0;
        end else begin
            pend_v    <= (state == ST_RUN) && !st_q;
            pend_reg  <= cur_reg;
            pend_lane <= cur_lane;
        end
    end

    // Memory port and completion outputs.
    always_comb begin
        mem_re      = (state == ST_RUN) && !st_q;
        mem_we      = (state == ST_RUN) && st_q;
        mem_addr    = cur_addr;
        mem_wdata   = store_byte;
        busy        = (state != ST_IDLE);
        done        = (state == ST_FIN);
        err_illegal = done && ill_q;
        err_fault   = done && flt_q;
        cost        = (done && !ill_q && !flt_q) ? COST_W'(FULL_COST) : '0;
    end

    // R9: done lasts a single cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: done is only seen while busy
    a_r9_busy_covers_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R8: no memory traffic while idle
    a_r8_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_re && !mem_we));

    // R2: read and write strobes never overlap
    a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

    // R4: a refused command goes straight from idle to done
    a_r4_refused_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (err_illegal || err_fault)) |-> ($past(state) == ST_IDLE));

    // R7: at most one error flag at a time
    a_r7_single_error: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_illegal && err_fault));

    // R10: the cycle charge appears only with done
    a_r10_cost_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        (cost != '0) |-> done);

    // R11: a start while busy does not restart the sequencer
    a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && step && !last) |=> (state == ST_RUN));

endmodule

// File: tb/test_rf_burst_mover.sv
// Scoreboard bench: the driver task queues expected memory writes and updates a
// shadow register file; a monitor pops writes and compares them as they appear.
module test_rf_burst_mover;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start, is_store, null_trap_en, region_chk_en;
    logic [31:0] cmd_addr, space_base;
    logic [6:0]  cmd_count;
    logic [4:0]  cmd_reg;
    logic [1:0]  cmd_lane;
    logic        busy, done, err_illegal, err_fault;
    logic [2:0]  cost;
    logic        mem_re, mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        rf_wr_en;
    logic [4:0]  rf_wr_idx, rf_rd_idx;
    logic [31:0] rf_wr_data, rf_rd_data;

    logic [7:0]  bmem [0:1023];
    logic [31:0] sh [0:31];
    logic [39:0] exp_q [$];
    int          n_chk = 0;
    int          n_bad = 0;
    int          n_re  = 0;
    int          n_we  = 0;

    always #4 clk = ~clk;

    rf_burst_mover i_rf_burst_mover (
        .clk(clk), .rst_n(rst_n), .start(start), .is_store(is_store),
        .cmd_addr(cmd_addr), .cmd_count(cmd_count), .cmd_reg(cmd_reg),
        .cmd_lane(cmd_lane), .null_trap_en(null_trap_en),
        .region_chk_en(region_chk_en), .space_base(space_base),
        .busy(busy), .done(done), .err_illegal(err_illegal),
        .err_fault(err_fault), .cost(cost), .mem_re(mem_re), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
        .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data)
    );

    // Byte memory model with one cycle of read latency.
    always @(posedge clk) begin
        if (mem_re) mem_rdata <= bmem[mem_addr[9:0]];
        if (mem_we) bmem[mem_addr[9:0]] <= mem_wdata;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compares each written byte against the queue, counts reads.
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (mem_we === 1'b1) begin
                n_we++;
                if (exp_q.size() == 0) begin
                    chk("R2 unexpected store byte", {mem_addr, mem_wdata}, 64'hffff_ffff_ffff);
                end else begin
                    chk("R2 store byte", {mem_addr, mem_wdata}, exp_q.pop_front());
                end
            end
            if (mem_re === 1'b1) n_re++;
        end
    end

    function automatic logic [31:0] pat(input int i);
        return {8'(i), 8'(~i), 8'(i ^ 8'h5a), 8'(8'hc3 + i)};
    endfunction

    // Driver: issue one command, build expectations, then check the outcome.
    task automatic run(input bit st, input int addr, input int cnt, input int rg, input int ln,
                       input bit e_ill, input bit e_flt, input string tag, input bit poke);
        int lat;
        int exp_lat;
        bit refused;
        refused = e_ill || e_flt;
        if (!refused) begin
            for (int i = 0; i < cnt; i++) begin
                int r;
                int l;
                r = rg + (ln + i) / 4;
                l = (ln + i) % 4;
                if (st) exp_q.push_back({32'(addr + i), sh[r][8*l +: 8]});
                else    sh[r][8*l +: 8] = bmem[(addr + i) % 1024];
            end
        end
        exp_lat = (refused || cnt == 0) ? 1 : (st ? cnt + 1 : cnt + 2);
        n_re = 0;
        n_we = 0;
        is_store  = st;
        cmd_addr  = 32'(addr);
        cmd_count = 7'(cnt);
        cmd_reg   = 5'(rg);
        cmd_lane  = 2'(ln);
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (done !== 1'b1 && lat < 400) begin
            if (poke && lat == 2) begin
                start      = 1'b1;
                is_store   = ~st;
                cmd_addr   = 32'h20;
                rf_wr_en   = 1'b1;
                rf_wr_idx  = 5'd7;
                rf_wr_data = 32'hdead_beef;
            end else begin
                start    = 1'b0;
                rf_wr_en = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start    = 1'b0;
        rf_wr_en = 1'b0;
        chk({tag, " R9 done latency"}, 64'(lat), 64'(exp_lat));
        chk({tag, " R4 err_illegal"}, 64'(err_illegal), 64'(e_ill));
        chk({tag, " R5 err_fault"}, 64'(err_fault), 64'(e_flt));
        chk({tag, " R10 cost"}, 64'(cost), refused ? 64'd0 : 64'd3);
        chk({tag, " R3 read count"}, 64'(n_re), (st || refused) ? 64'd0 : 64'(cnt));
        chk({tag, " R2 write count"}, 64'(n_we), (!st || refused) ? 64'd0 : 64'(cnt));
        chk({tag, " R2 queue drained"}, 64'(exp_q.size()), 64'd0);
        exp_q.delete();
        @(negedge clk);
        chk({tag, " R9 busy cleared"}, 64'(busy), 64'd0);
        chk({tag, " R11 no second done"}, 64'(done), 64'd0);
        for (int r = 0; r < 32; r++) begin
            rf_rd_idx = 5'(r);
            #1;
            chk({tag, " R3 register image"}, 64'(rf_rd_data), 64'(sh[r]));
        end
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) bmem[i] = 8'(i * 7 + 3);
        mem_rdata = 8'h00;
        rst_n = 1'b0;
        start = 1'b0; is_store = 1'b0; null_trap_en = 1'b0; region_chk_en = 1'b0;
        cmd_addr = '0; cmd_count = '0; cmd_reg = '0; cmd_lane = '0; space_base = '0;
        rf_wr_en = 1'b0; rf_wr_idx = '0; rf_wr_data = '0; rf_rd_idx = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 done", 64'(done), 64'd0);
        chk("R1 errors", 64'({err_illegal, err_fault}), 64'd0);
        chk("R1 strobes", 64'({mem_re, mem_we}), 64'd0);
        chk("R1 cost", 64'(cost), 64'd0);
        rf_rd_idx = 5'd31;
        #1;
        chk("R1 register zero", 64'(rf_rd_data), 64'd0);
        @(negedge clk);
        for (int r = 0; r < 32; r++) begin
            rf_wr_en = 1'b1; rf_wr_idx = 5'(r); rf_wr_data = pat(r);
            sh[r] = pat(r);
            @(negedge clk);
        end
        rf_wr_en = 1'b0;

        run(1, 'h40, 9, 2, 1, 0, 0, "R2 store across two boundaries", 0);
        run(1, 'h10, 1, 0, 0, 0, 0, "R2 single byte store", 0);
        run(0, 'h100, 6, 5, 3, 0, 0, "R3 load from lane 3", 0);
        run(0, 'h40, 9, 12, 2, 0, 0, "R3 load back stored run", 0);
        run(0, 'h180, 8, 30, 0, 0, 0, "R12 R4 load into r30 r31 at limit", 0);
        run(0, 'h60, 3, 31, 2, 1, 0, "R4 load overrun", 0);
        run(1, 'h60, 13, 29, 0, 1, 0, "R4 store overrun", 0);
        null_trap_en = 1'b1;
        run(0, 2, 4, 1, 0, 0, 1, "R5 trapped low address", 0);
        run(1, 4, 4, 3, 0, 0, 0, "R5 address 4 allowed", 0);
        run(0, 1, 5, 31, 3, 0, 1, "R7 fault beats overrun", 0);
        null_trap_en = 1'b0;
        run(1, 0, 2, 4, 2, 0, 0, "R5 trap off address 0", 0);
        region_chk_en = 1'b1;
        space_base = 32'h200;
        run(1, 'h1fc, 4, 6, 1, 0, 0, "R6 run ends at base", 0);
        run(1, 'h1fd, 4, 6, 1, 0, 1, "R6 run crosses base", 0);
        run(0, 'h200, 1, 9, 0, 0, 1, "R6 run starts at base", 0);
        region_chk_en = 1'b0;
        run(1, 'h80, 0, 10, 0, 0, 0, "R8 zero store", 0);
        run(0, 'h80, 0, 10, 0, 0, 0, "R8 zero load", 0);
        run(1, 'h300, 6, 8, 2, 0, 0, "R11 start and write while busy", 1);
        run(0, 'h300, 6, 20, 1, 0, 0, "R3 reload poked run", 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule